// File: doc/BRIEF.md
# ADC Master-Mode Serial Data Streamer

This block sends the 16-bit result of a successive-approximation converter to a host over a serial link. The block generates its own serial clock and drives the data line. A start strobe begins a conversion. A behavioural down-counter of `CONV_CYCLES` system clocks stands in for the analog core. When the counter expires, the block takes the result word presented on `conv_result`.

A mode input chooses when the word goes out:

- **After-conversion mode** (`rd_during = 0`): the freshly converted word is shifted out once the conversion ends. BUSY stays high until the last bit has gone.
- **During-conversion mode** (`rd_during = 1`): the word latched at the end of the previous conversion is shifted out while the new conversion runs. BUSY covers only the conversion.

A divider select sets the serial clock rate so that slow hosts can keep up. Mode and divider are sampled when a start is accepted and hold for that conversion.

Top module: `adc_serial_streamer`

## Requirements
- R1: While reset is asserted, and on release, `busy`, `sclk` and `sdout` are low.
- R2: In during-conversion mode, `busy` is high for exactly `CONV_CYCLES` clock cycles after an accepted start.
- R3: In after-conversion mode, `busy` is high for `CONV_CYCLES + 32*2^div_sel` cycles. It falls on the same edge as the sixteenth falling edge of `sclk`.
- R4: Each word is sent as exactly 16 `sclk` pulses, most significant bit first. `sdout` changes only on a falling `sclk` edge, so each bit is steady across both edges of its pulse.
- R5: In after-conversion mode, the word sent is `conv_result` as sampled on the cycle the conversion ends.
- R6: In during-conversion mode, the word sent is the result latched at the end of the previous conversion. The first conversion after reset sends 16 zeros.
- R7: `sclk` has a period of `2*2^div_sel` system clocks, where `div_sel` 0..3 gives ratios 1, 2, 4 and 8. `sclk` stays low whenever no word is in flight.
- R8: A start strobe is ignored while `busy` is high or a word is still being shifted. It alters neither the `busy` width nor the serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_start | input | 1 | Conversion start strobe |
| rd_during | input | 1 | 1: stream previous word during conversion; 0: stream after conversion |
| div_sel | input | 2 | Serial clock divide select (ratio 2^div_sel) |
| conv_result | input | DATA_W | Converter result, sampled at end of conversion |
| sclk | output | 1 | Generated serial clock, idles low |
| sdout | output | 1 | Serial data, MSB first |
| busy | output | 1 | Conversion (and, in after mode, transfer) in progress |

## Verification
The assertions assume that `conv_result` is steady on the cycle the conversion ends. They also assume that mode and divider changes only matter at an accepted start. The stimulus sets every input on the falling clock edge before a start, and holds `conv_result` until the word has been observed. Extra start pulses are placed deliberately inside the busy window and inside the shift window, where the block must reject them. A fresh reset precedes the check that the first word in during-conversion mode is zero.

// File: rtl/adc_serial_streamer.sv
module adc_serial_streamer #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_start,
  input  logic              rd_during,
  input  logic [1:0]        div_sel,
  input  logic [DATA_W-1:0] conv_result,
  output logic              sclk,
  output logic              sdout,
  output logic              busy
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(DATA_W + 1);

  logic [CW-1:0]     conv_cnt;
  logic              during_q;
  logic [1:0]        div_q;
  logic [7:0]        div_cnt;
  logic [DATA_W-1:0] held, sh;
  logic              shifting, sclk_r;
  logic [BW-1:0]     bit_cnt;

  wire              converting = (conv_cnt != '0);
  wire              eoc        = (conv_cnt == CW'(1));
  wire              accept     = cnv_start & ~busy & ~shifting;
  wire              load_now   = (accept & rd_during) | (eoc & ~during_q);
  wire [DATA_W-1:0] load_word  = accept ? held : conv_result;
  wire [7:0]        half_m1    = (8'd1 << div_q) - 8'd1;

  assign busy  = converting | (~during_q & shifting);
  assign sclk  = sclk_r;
  assign sdout = sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_cnt <= '0;
      during_q <= 1'b0;
      div_q    <= '0;
      div_cnt  <= '0;
      held     <= '0;
      sh       <= '0;
      shifting <= 1'b0;
      sclk_r   <= 1'b0;
      bit_cnt  <= '0;
    end else begin
      if (accept) begin
        conv_cnt <= CW'(CONV_CYCLES);
        during_q <= rd_during;
        div_q    <= div_sel;
      end else if (converting) begin
        conv_cnt <= conv_cnt - CW'(1);
      end
      if (eoc) held <= conv_result;

      if (load_now) begin
        sh       <= load_word;
        shifting <= 1'b1;
        bit_cnt  <= '0;
        div_cnt  <= '0;
        sclk_r   <= 1'b0;
      end else if (shifting) begin
        if (div_cnt == half_m1) begin
          div_cnt <= '0;
          sclk_r  <= ~sclk_r;
          if (sclk_r) begin
            sh      <= {sh[DATA_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + BW'(1);
            if (bit_cnt == BW'(DATA_W - 1)) shifting <= 1'b0;
          end
        end else begin
          div_cnt <= div_cnt + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_streamer_chk.sv
module adc_serial_streamer_chk #(
  parameter int CONV_CYCLES = 24,
  localparam int CW = $clog2(CONV_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnv_start,
  input logic          busy,
  input logic          sclk,
  input logic          sdout,
  input logic          shifting,
  input logic          converting,
  input logic          during_q,
  input logic [CW-1:0] conv_cnt
);
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> !sclk);

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdout));

  p_busy_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !during_q) |-> $fell(shifting));

  p_busy_covers_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> busy);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && converting) |=> (conv_cnt == $past(conv_cnt) - CW'(1)));
endmodule

bind adc_serial_streamer adc_serial_streamer_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .busy(busy),
  .sclk(sclk), .sdout(sdout), .shifting(shifting), .converting(converting),
  .during_q(during_q), .conv_cnt(conv_cnt));

// File: tb/test_adc_serial_streamer.sv
module test_adc_serial_streamer;
  localparam int PERIOD = 10;
  localparam int CONV   = 24;
  localparam int NVEC   = 8;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 16'hA55A}, {1'b1, 2'd0, 16'h1234},
    {1'b1, 2'd1, 16'hBEEF}, {1'b0, 2'd2, 16'h8001},
    {1'b1, 2'd3, 16'h0F0F}, {1'b0, 2'd3, 16'hFFFF},
    {1'b0, 2'd1, 16'h0001}, {1'b1, 2'd2, 16'h7FFE}};

  logic clk = 0, rst_n = 0, cnv_start = 0, rd_during = 0;
  logic [1:0] div_sel = 0;
  logic [15:0] conv_result = 0;
  logic sclk, sdout, busy;
  int checks = 0, fails = 0;

  adc_serial_streamer #(.DATA_W(16), .CONV_CYCLES(CONV)) i_adc_serial_streamer (
    .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .rd_during(rd_during),
    .div_sel(div_sel), .conv_result(conv_result), .sclk(sclk), .sdout(sdout), .busy(busy));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cnv_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_conv(input logic m, input logic [1:0] d, input logic [15:0] r,
                          input int extra_at, output logic [15:0] w,
                          output int bw, output int nb, output int per);
    int ps, r1, r2;
    @(negedge clk);
    rd_during = m; div_sel = d; conv_result = r; cnv_start = 1;
    @(negedge clk);
    cnv_start = 0;
    w = 0; bw = 0; nb = 0; ps = 0; r1 = -1; r2 = -1;
    for (int c = 0; c < 2000; c++) begin
      cnv_start = (c == extra_at);
      if (busy) bw++;
      if (sclk && !ps) begin
        w = {w[14:0], sdout}; nb++;
        if (r1 < 0) r1 = c; else if (r2 < 0) r2 = c;
      end
      ps = sclk;
      if (c > 0 && !busy && !sclk && nb >= 16 && c > extra_at) break;
      @(negedge clk);
    end
    cnv_start = 0;
    per = r2 - r1;
  endtask

  task automatic quiet(input string req, input int n);
    int act = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (busy || sclk) act++;
    end
    check(req, act, 0);
  endtask

  initial begin
    logic [15:0] w, prev, exp;
    int bw, nb, per;
    do_reset();
    check("R1 busy", busy, 0); check("R1 sclk", sclk, 0); check("R1 sdout", sdout, 0);

    prev = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic m = VEC[i][18];
      logic [1:0] d = VEC[i][17:16];
      logic [15:0] r = VEC[i][15:0];
      run_conv(m, d, r, -1, w, bw, nb, per);
      exp = m ? prev : r;
      prev = r;
      check(m ? "R6 word" : "R5 word", w, exp);
      check(m ? "R2 busy width" : "R3 busy width", bw, CONV + (m ? 0 : (32 << d)));
      check("R4 bit count", nb, 16);
      check("R7 sclk period", per, 2 << d);
      check("R7 sclk idle", sclk, 0);
    end

    // R6: first during-mode word after reset is zero
    do_reset();
    run_conv(1'b1, 2'd0, 16'hC3C3, -1, w, bw, nb, per);
    check("R6 first word zero", w, 0);
    check("R2 busy width", bw, CONV);

    // R8: start inside busy window (after mode) is ignored
    run_conv(1'b0, 2'd1, 16'h5A5A, 10, w, bw, nb, per);
    check("R8 busy width", bw, CONV + 64);
    check("R8 word", w, 16'h5A5A);
    check("R8 bits", nb, 16);
    quiet("R8 no second word", 100);

    // R8: start after busy fell but while shifting (during mode) is ignored
    run_conv(1'b1, 2'd3, 16'h0000, CONV + 20, w, bw, nb, per);
    check("R8 during word", w, 16'h5A5A);
    check("R8 during busy", bw, CONV);
    quiet("R8 during no restart", 100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule